// File: doc/BRIEF.md
# Inter-Hart Software Interrupt Controller

This block lets any of four harts raise an inter-processor interrupt on any other hart. Each sending hart owns one byte of a single 32-bit pending word; inside that byte the upper four bits each name one receiving hart in reverse order. Software sets a bit by writing a one to it. Each receiving hart has an enable word, a set of per-source priorities and a claim/complete register. Each hart has one interrupt line, driven high while it has work waiting.

A receiving hart services its interrupt by reading its claim register. The read returns the ID of the best waiting source and clears that source's pending bit in the same access. The source is then held as in service for that hart until the hart writes the same ID back. Software normally programs a rotating enable pattern, `0x80808080 >> t` for hart t, so that each pending bit reaches exactly one receiver. Source ID k is pending bit k. Source 0 has no priority register and never signals.

All access goes through a simple 32-bit register bus with one request per cycle. Read data is registered.

Top module: `swi_ctrl`

## Requirements
- R1: After reset every register is zero, all interrupt lines are low, and reads of the pending, enable and claim registers return 0.
- R2: The pending word at byte offset 0x1000 is write-one-to-set: ones in the write data set bits and zeros leave bits unchanged. Sender S signals target T by setting bit 8*S + (7 - T).
- R3: The priority of source k (1 to 31) is a 3-bit field at offset 4*k, read back zero-extended. The upper write bits are dropped.
- R4: The enable word of target t is at offset 0x2000 + 0x80*t and reads back as written.
- R5: irq_o[t] is high exactly when some source is pending, enabled for t, not in service for t, and of nonzero priority.
- R6: A read of the claim register at 0x200004 + 0x1000*t returns the qualifying source of highest priority, with ties going to the lowest ID. The same read clears that source's pending bit and marks it in service for t.
- R7: A claim read when no source qualifies returns 0 and changes no state.
- R8: A source in service for t may be pended again, but it does not signal t until t writes its ID to t's claim register.
- R9: A completion write whose value is not an ID in service for that target is ignored.
- R10: Unmapped or unaligned addresses read as 0 and ignore writes. Offset 0, enable words for targets above 3 and contexts above 3 are all unmapped.
- R11: Read data appears on bus_rdata in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_o | output | 4 | Interrupt line per hart |

## Verification
A pending bit that is routed wrongly shows up as the wrong line in irq_o, at the clock edge that follows the pending write. A broken arbitration order or a missed clear shows up in the ID returned by the next claim read, or in the line staying high after that read. In-service state that is lost or stuck is visible on the line itself: it either rises too early while the source is still re-pended or stays low after a correct completion write. Every such error is therefore visible at the ports within one or two bus accesses.

// File: rtl/swi_pkg.sv
package swi_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PEND,
    RK_PRIO,
    RK_EN,
    RK_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } reg_dec_t;

  // True when addr lies on sub-offset 'sub' of one of 'count' slots of size 'stride' from 'base'.
  function automatic logic slot_hit(logic [31:0] addr, logic [31:0] base,
                                    logic [31:0] stride, logic [31:0] count,
                                    logic [31:0] sub);
    logic [31:0] rel;
    rel = addr - base;
    return (addr >= base) && (rel < stride * count) && ((rel & (stride - 1)) == sub);
  endfunction

  // Slot index of addr within a region of power-of-two stride.
  function automatic logic [7:0] slot_idx(logic [31:0] addr, logic [31:0] base, int unsigned sh);
    logic [31:0] rel;
    rel = (addr - base) >> sh;
    return rel[7:0];
  endfunction

endpackage

// File: rtl/swi_addr_decode.sv
module swi_addr_decode
  import swi_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int NUM_HARTS = 4,
  parameter int NUM_SRC   = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_dec_t          dec_o
);
  localparam logic [31:0] PEND_OFS   = 32'h0000_1000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  localparam logic [31:0] CLAIM_SUB  = 32'h0000_0004;
  localparam logic [31:0] HARTS_L    = 32'(NUM_HARTS);
  localparam logic [31:0] PRIO_END   = 32'(4 * NUM_SRC);

  logic [31:0] a;

  always_comb begin
    a     = 32'(addr_i);
    dec_o = '{kind: RK_NONE, idx: 8'd0};
    if (a == PEND_OFS) begin
      dec_o.kind = RK_PEND;
    end else if (a[1:0] == 2'b00 && a >= 32'd4 && a < PRIO_END) begin
      dec_o.kind = RK_PRIO;
      dec_o.idx  = slot_idx(a, 32'd0, 2);
    end else if (slot_hit(a, EN_BASE, EN_STRIDE, HARTS_L, 32'd0)) begin
      dec_o.kind = RK_EN;
      dec_o.idx  = slot_idx(a, EN_BASE, $clog2(EN_STRIDE));
    end else if (slot_hit(a, CTX_BASE, CTX_STRIDE, HARTS_L, CLAIM_SUB)) begin
      dec_o.kind = RK_CLAIM;
      dec_o.idx  = slot_idx(a, CTX_BASE, $clog2(CTX_STRIDE));
    end
  end
endmodule

// File: rtl/swi_claim_arb.sv
module swi_claim_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        cand_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic [IDX_W-1:0]          id_o
);
  logic [PRIO_W-1:0] best_p;

  // Strict greater-than keeps the lowest ID on ties; priority 0 never wins.
  always_comb begin
    best_p = '0;
    id_o   = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (cand_i[i] && prio_i[i*PRIO_W +: PRIO_W] > best_p) begin
        best_p = prio_i[i*PRIO_W +: PRIO_W];
        id_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/swi_inservice.sv
module swi_inservice #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               claim_en,
  input  logic [IDX_W-1:0]   claim_id,
  input  logic               done_en,
  input  logic [31:0]        done_data,
  output logic [NUM_SRC-1:0] svc_o
);
  logic [NUM_SRC-1:0] svc_q;
  logic               done_ok;
  logic [IDX_W-1:0]   done_id;

  assign done_id = done_data[IDX_W-1:0];
  assign done_ok = done_en && (done_data < 32'(NUM_SRC)) && svc_q[done_id];
  assign svc_o   = svc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q <= '0;
    end else begin
      if (claim_en && claim_id != '0) svc_q[claim_id] <= 1'b1;
      if (done_ok) svc_q[done_id] <= 1'b0;
    end
  end

  AST_CLAIM_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_en && claim_id != '0) |=> svc_q[$past(claim_id)]); // R6

  AST_BAD_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_en && !claim_en && !(done_data < 32'(NUM_SRC) && svc_q[done_id])) |=> $stable(svc_q)); // R9
endmodule

// File: rtl/swi_ctrl.sv
module swi_ctrl
  import swi_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int NUM_HARTS    = 4,
  parameter int SRC_PER_HART = 8,
  parameter int PRIO_W       = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] irq_o
);
  localparam int NUM_SRC = NUM_HARTS * SRC_PER_HART;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int HART_W  = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  reg_dec_t dec;
  logic     rd_req, wr_req;

  logic [NUM_SRC-1:0]        pend_q;
  logic [NUM_SRC-1:0]        en_q   [NUM_HARTS];
  logic [PRIO_W-1:0]         prio_q [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]        prio_nz;
  logic [NUM_SRC-1:0]        svc    [NUM_HARTS];
  logic [NUM_SRC-1:0]        cand   [NUM_HARTS];
  logic [IDX_W-1:0]          arb_id [NUM_HARTS];

  logic              claim_fire, claim_hit, done_fire, pend_wr;
  logic [HART_W-1:0] sel_tgt;
  logic [IDX_W-1:0]  claim_id;
  logic [IDX_W-1:0]  prio_idx;
  logic [31:0]       rd_val;

  swi_addr_decode #(.ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS), .NUM_SRC(NUM_SRC)) u_dec (
    .addr_i (bus_addr),
    .dec_o  (dec)
  );

  assign rd_req     = bus_sel && !bus_wr;
  assign wr_req     = bus_sel && bus_wr;
  assign sel_tgt    = dec.idx[HART_W-1:0];
  assign prio_idx   = dec.idx[IDX_W-1:0];
  assign claim_fire = rd_req && dec.kind == RK_CLAIM;
  assign done_fire  = wr_req && dec.kind == RK_CLAIM;
  assign pend_wr    = wr_req && dec.kind == RK_PEND;
  assign claim_id   = claim_fire ? arb_id[sel_tgt] : '0;
  assign claim_hit  = claim_fire && claim_id != '0;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
      assign prio_nz[s] = prio_q[s] != '0;
    end

    for (genvar t = 0; t < NUM_HARTS; t++) begin : g_tgt
      logic mine;
      assign mine    = HART_W'(t) == sel_tgt;
      assign cand[t] = pend_q & en_q[t] & ~svc[t];
      assign irq_o[t] = |(cand[t] & prio_nz);

      swi_claim_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .cand_i (cand[t]),
        .prio_i (prio_flat),
        .id_o   (arb_id[t])
      );

      swi_inservice #(.NUM_SRC(NUM_SRC)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim_en  (claim_fire && mine),
        .claim_id  (claim_id),
        .done_en   (done_fire && mine),
        .done_data (bus_wdata),
        .svc_o     (svc[t])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q[t] <= '0;
        else if (wr_req && dec.kind == RK_EN && mine) en_q[t] <= bus_wdata[NUM_SRC-1:0];
      end

      AST_IRQ_AGREES_ARB: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[t] == (arb_id[t] != '0)); // R5
    end
  endgenerate

  // Pending word: write-one-to-set, cleared only by a successful claim.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      if (pend_wr) pend_q <= pend_q | bus_wdata[NUM_SRC-1:0];
      else if (claim_hit) pend_q[claim_id] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
    end else if (wr_req && dec.kind == RK_PRIO) begin
      prio_q[prio_idx] <= bus_wdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (dec.kind)
      RK_PEND:  rd_val = 32'(pend_q);
      RK_PRIO:  rd_val = 32'(prio_q[prio_idx]);
      RK_EN:    rd_val = 32'(en_q[sel_tgt]);
      RK_CLAIM: rd_val = 32'(claim_id);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_val;
  end

  AST_PEND_WRITE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R2

  AST_CLAIM_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    claim_hit |=> !pend_q[$past(claim_id)]); // R6

  AST_EMPTY_CLAIM_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && !claim_hit) |=> $stable(pend_q)); // R7

  AST_UNMAPPED_WRITE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && dec.kind == RK_NONE) |=> ($stable(pend_q) && $stable(irq_o))); // R10
endmodule

// File: tb/swi_ctrl_tb.sv
module swi_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk; // 50 MHz

  swi_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic logic [23:0] a_prio(int k);  return 24'(4 * k); endfunction
  function automatic logic [23:0] a_en(int t);    return 24'(32'h2000 + 32'h80 * t); endfunction
  function automatic logic [23:0] a_claim(int t); return 24'(32'h200004 + 32'h1000 * t); endfunction
  function automatic int src_id(int s, int t);    return 8 * s + (7 - t); endfunction
  localparam logic [23:0] A_PEND = 24'h001000;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [23:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // R11: data is sampled one cycle after the request.
  task automatic rd(logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", 32'(irq_o), 32'h0);
    rd(A_PEND, rv);   check("R1 pend", rv, 32'h0);
    rd(a_en(2), rv);  check("R1 en", rv, 32'h0);
    rd(a_claim(0), rv); check("R1 R7 R11 empty claim", rv, 32'h0);

    // R3 priorities
    for (int k = 1; k < 32; k++) wr(a_prio(k), 32'h1);
    wr(a_prio(5), 32'hFFFF_FFFF);
    rd(a_prio(5), rv); check("R3 prio trunc", rv, 32'h7);
    wr(a_prio(5), 32'h1);
    rd(a_prio(9), rv); check("R3 prio", rv, 32'h1);

    // R4 enables
    for (int t = 0; t < 4; t++) wr(a_en(t), 32'h8080_8080 >> t);
    for (int t = 0; t < 4; t++) begin
      rd(a_en(t), rv); check("R4 en readback", rv, 32'h8080_8080 >> t);
    end

    // R2 R5 R6 sweep over every sender/target pair
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        wr(A_PEND, 32'h1 << src_id(s, t));
        rd(A_PEND, rv); check("R2 pend bit", rv, 32'h1 << src_id(s, t));
        check("R5 irq route", 32'(irq_o), 32'h1 << t);
        rd(a_claim(t), rv); check("R6 claim id", rv, 32'(src_id(s, t)));
        check("R6 irq after claim", 32'(irq_o), 32'h0);
        rd(A_PEND, rv); check("R6 pend cleared", rv, 32'h0);
        wr(a_claim(t), 32'(src_id(s, t)));
      end
    end

    // R6 priority order and tie break
    wr(a_prio(15), 32'h2); wr(a_prio(23), 32'h2);
    wr(A_PEND, 32'h0080_8080);
    check("R5 irq multi", 32'(irq_o), 32'h1);
    rd(a_claim(0), rv); check("R6 highest prio lowest id", rv, 32'd15);
    rd(a_claim(0), rv); check("R6 second", rv, 32'd23);
    rd(a_claim(0), rv); check("R6 third", rv, 32'd7);
    rd(a_claim(0), rv); check("R7 none left", rv, 32'd0);
    check("R5 irq all claimed", 32'(irq_o), 32'h0);
    wr(a_claim(0), 32'd15); wr(a_claim(0), 32'd23); wr(a_claim(0), 32'd7);
    wr(a_prio(15), 32'h1); wr(a_prio(23), 32'h1);

    // R8 R9 in-service gating
    wr(A_PEND, 32'h80);
    rd(a_claim(0), rv); check("R8 claim", rv, 32'd7);
    wr(A_PEND, 32'h80);
    check("R8 repend masked", 32'(irq_o), 32'h0);
    rd(A_PEND, rv); check("R8 repend stored", rv, 32'h80);
    wr(a_claim(0), 32'd15);
    check("R9 wrong id", 32'(irq_o), 32'h0);
    wr(a_claim(1), 32'd7);
    check("R9 wrong target", 32'(irq_o), 32'h0);
    wr(a_claim(0), 32'd7);
    check("R8 after complete", 32'(irq_o), 32'h1);
    rd(a_claim(0), rv); check("R8 reclaim", rv, 32'd7);
    wr(a_claim(0), 32'd7);

    // R5 R7 R2 priority zero
    wr(a_prio(7), 32'h0);
    wr(A_PEND, 32'h80);
    check("R5 prio zero", 32'(irq_o), 32'h0);
    rd(a_claim(0), rv); check("R7 prio zero claim", rv, 32'd0);
    rd(A_PEND, rv); check("R7 pend kept", rv, 32'h80);
    wr(A_PEND, 32'h0);
    rd(A_PEND, rv); check("R2 zero write", rv, 32'h80);
    wr(a_prio(7), 32'h1);
    check("R5 prio restored", 32'(irq_o), 32'h1);
    rd(a_claim(0), rv); check("R6 claim", rv, 32'd7);
    wr(a_claim(0), 32'd7);

    // R10 unmapped
    wr(24'h003000, 32'hFFFF_FFFF);
    rd(24'h003000, rv); check("R10 hole", rv, 32'h0);
    wr(24'h000000, 32'h7);
    rd(24'h000000, rv); check("R10 offset0", rv, 32'h0);
    wr(24'h001001, 32'hFFFF_FFFF);
    rd(A_PEND, rv); check("R10 unaligned", rv, 32'h0);
    check("R10 irq", 32'(irq_o), 32'h0);
    wr(a_en(4), 32'hFFFF_FFFF);
    rd(a_en(4), rv); check("R10 en4", rv, 32'h0);
    rd(a_claim(4), rv); check("R10 ctx4", rv, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule